// File: doc/BRIEF.md
# Free-Running Compare Timer

This peripheral keeps a 32-bit up-counter that never reloads, a compare register, a sticky match flag and an interrupt gate. Software sets it up and reads it through a small synchronous register bus. The counter advances on count ticks. A count tick comes from one of three tick-enable inputs, chosen by a select field. The selected tick then passes through a programmable main prescaler. The oscillator tick can also go through its own pre-divider first, and that pre-divider has its own enable bit.

The counter wraps from all ones to zero. A compare match never resets it. A match sets a flag that stays set until software writes 1 to it. The interrupt line is high while that flag and the interrupt-enable bit are both set. A wait-request input can freeze counting unless the control register allows counting during wait.

Register word offsets are: 0x00 control, 0x04 prescaler, 0x08 compare, 0x0C status, 0x10 interrupt enable, 0x14 counter (read-only). Only `bus_addr[4:2]` is decoded.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register, the counter and both divider phases are zero, so every register reads 0 and `irq` is low.
- R2: Control bit 0 enables counting. While it is clear, the counter, the main prescaler phase and the oscillator pre-divider phase all hold.
- R3: Control bits 8:6 pick the count source: code 1 is `tick_bus`, code 2 is `tick_per`, code 5 is the oscillator path from `tick_osc`. Any other code gives no count ticks.
- R4: Prescaler bits 11:0 hold a value P. The counter advances once per P+1 ticks of the selected source.
- R5: When control bit 10 is set, the oscillator path passes one `tick_osc` in Q+1, where Q is prescaler bits 15:12. When bit 10 is clear, every `tick_osc` passes.
- R6: A write to the prescaler register clears both divider phases, so the next count comes a full period after that write.
- R7: The counter only ever steps by one and wraps from its maximum to zero. It never reloads on a match (control bit 9 is stored and read back only).
- R8: The status flag (bit 0) sets on the count tick where the counter changes to equal the compare value. A compare value that already equals the count does not fire until the counter comes round to it again.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a match and a clear fall in the same cycle, the flag ends up set.
- R10: `irq` equals the status flag ANDed with interrupt-enable bit 0.
- R11: With control bit 3 clear and `wait_req` high, counting stops. With bit 3 set, `wait_req` has no effect.
- R12: Control keeps bits 0, 3 and 10:6, and its other bits read 0. Compare reads back its counter-width value. A write to the counter offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (5) | Byte address, bits 4:2 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_bus | input | 1 | Bus-clock tick enable |
| tick_per | input | 1 | Peripheral-clock tick enable |
| tick_osc | input | 1 | Oscillator tick enable |
| wait_req | input | 1 | Wait-mode request |
| irq | output | 1 | Level interrupt |

## Verification
The counter is tried with each source code, each with only its own tick active and then with all ticks active under an unused code. This shows whether the select decode picks the right input. Main and oscillator divide ratios are run on steady ticks and then rewritten mid-phase, which separates a divider that restarts from one that free-runs. Several compare cases are covered: a value ahead of the count, a value equal to the count, and a clear written on the very cycle of a match. These tell a flag on change from a flag on equality, and show which of set and clear wins. A long seeded random mix of writes, reads, sparse ticks and wait requests is checked every cycle against a bench model.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CW = 32,
  parameter int PW = 12,
  parameter int OW = 4,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_bus,
  input  logic          tick_per,
  input  logic          tick_osc,
  input  logic          wait_req,
  output logic          irq
);
  localparam int IW = AW - 2;
  localparam int OSC_LSB = 12;
  localparam logic [10:0] CTRL_KEEP = 11'b111_1100_1001;

  logic [10:0]   ctrl_q;
  logic [PW-1:0] pre_main_q, pc_q;
  logic [OW-1:0] pre_osc_q, oc_q;
  logic [CW-1:0] cmp_q, cnt_q, cnt_nxt;
  logic          flag_q, ier_q;
  logic          run, osc_last, osc_tick, src, src_run, cnt_tick, hit;
  logic          wr_ctrl, wr_pre, wr_cmp, wr_stat, wr_ier;
  logic [IW-1:0] idx;
  logic          unused_bits;

  assign idx     = bus_addr[AW-1:2];
  assign wr_ctrl = bus_sel & bus_wr & (idx == IW'(0));
  assign wr_pre  = bus_sel & bus_wr & (idx == IW'(1));
  assign wr_cmp  = bus_sel & bus_wr & (idx == IW'(2));
  assign wr_stat = bus_sel & bus_wr & (idx == IW'(3));
  assign wr_ier  = bus_sel & bus_wr & (idx == IW'(4));
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  assign run      = ctrl_q[0] & ~(wait_req & ~ctrl_q[3]);
  assign osc_last = (oc_q == pre_osc_q);
  assign osc_tick = ctrl_q[10] ? (tick_osc & osc_last) : tick_osc;

  always_comb begin
    case (ctrl_q[8:6])
      3'd1:    src = tick_bus;
      3'd2:    src = tick_per;
      3'd5:    src = osc_tick;
      default: src = 1'b0;
    endcase
  end

  assign src_run  = run & src;
  assign cnt_tick = src_run & (pc_q == pre_main_q);
  assign cnt_nxt  = cnt_q + CW'(1);
  assign hit      = cnt_tick & (cnt_nxt == cmp_q);
  assign irq      = flag_q & ier_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      pre_main_q <= '0;
      pre_osc_q  <= '0;
      pc_q       <= '0;
      oc_q       <= '0;
      cmp_q      <= '0;
      cnt_q      <= '0;
      flag_q     <= 1'b0;
      ier_q      <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[10:0] & CTRL_KEEP;
      if (wr_pre) begin
        pre_main_q <= bus_wdata[PW-1:0];
        pre_osc_q  <= bus_wdata[OSC_LSB +: OW];
        pc_q       <= '0;
        oc_q       <= '0;
      end else begin
        if (src_run) pc_q <= cnt_tick ? '0 : pc_q + PW'(1);
        if (run & ctrl_q[10] & tick_osc) oc_q <= osc_last ? '0 : oc_q + OW'(1);
      end
      if (wr_cmp) cmp_q <= bus_wdata[CW-1:0];
      if (wr_ier) ier_q <= bus_wdata[0];
      if (cnt_tick) cnt_q <= cnt_nxt;
      if (hit) flag_q <= 1'b1;
      else if (wr_stat & bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IW'(0): bus_rdata[10:0] = ctrl_q;
      IW'(1): begin
        bus_rdata[PW-1:0]        = pre_main_q;
        bus_rdata[OSC_LSB +: OW] = pre_osc_q;
      end
      IW'(2): bus_rdata[CW-1:0] = cmp_q;
      IW'(3): bus_rdata[0]      = flag_q;
      IW'(4): bus_rdata[0]      = ier_q;
      IW'(5): bus_rdata[CW-1:0] = cnt_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CW = 32,
  parameter int PW = 12,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          waiten,
  input logic          wait_req,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic          flag,
  input logic          ier,
  input logic          irq,
  input logic          clr,
  input logic          pre_wr,
  input logic [PW-1:0] pc,
  input logic [OW-1:0] oc
);
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == $past(cnt)); // R2

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> (pc == '0) && (oc == '0)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CW'($past(cnt) + CW'(1)))); // R7

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == $past(cmp)) && (cnt != $past(cnt))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ier |-> !irq); // R10

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !waiten && wait_req) |=> cnt == $past(cnt)); // R11
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW), .PW(PW), .OW(OW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (ctrl_q[0]),
  .waiten   (ctrl_q[3]),
  .wait_req (wait_req),
  .cnt      (cnt_q),
  .cmp      (cmp_q),
  .flag     (flag_q),
  .ier      (ier_q),
  .irq      (irq),
  .clr      (wr_stat & bus_wdata[0]),
  .pre_wr   (wr_pre),
  .pc       (pc_q),
  .oc       (oc_q)
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  localparam int CW = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_PRE = 5'h04, A_CMP = 5'h08,
                         A_STAT = 5'h0C, A_IER = 5'h10, A_CNT = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bsel = 1'b0, bwr = 1'b0;
  logic [4:0] baddr = '0;
  logic [31:0] bwd = '0, rdata;
  logic t_bus = 1'b0, t_per = 1'b0, t_osc = 1'b0, wreq = 1'b0, irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer #(.CW(CW)) u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr), .bus_addr(baddr),
    .bus_wdata(bwd), .bus_rdata(rdata), .tick_bus(t_bus), .tick_per(t_per),
    .tick_osc(t_osc), .wait_req(wreq), .irq(irq));

  logic [10:0] m_ctrl;
  logic [11:0] m_pm, m_pc;
  logic [3:0]  m_po, m_oc;
  logic [CW-1:0] m_cmp, m_cnt;
  logic m_flag, m_ier;

  always @(posedge clk) begin
    logic run, ot, s, sr, ct, hit, w;
    logic [CW-1:0] nx;
    logic [2:0] i;
    if (!rst_n) begin
      m_ctrl = '0; m_pm = '0; m_pc = '0; m_po = '0; m_oc = '0;
      m_cmp = '0; m_cnt = '0; m_flag = 1'b0; m_ier = 1'b0;
    end else begin
      run = m_ctrl[0] && !(wreq && !m_ctrl[3]);
      ot  = m_ctrl[10] ? (t_osc && m_oc == m_po) : t_osc;
      case (m_ctrl[8:6])
        3'd1: s = t_bus;
        3'd2: s = t_per;
        3'd5: s = ot;
        default: s = 1'b0;
      endcase
      sr  = run && s;
      ct  = sr && (m_pc == m_pm);
      nx  = m_cnt + 1'b1;
      hit = ct && (nx == m_cmp);
      w   = bsel && bwr;
      i   = baddr[4:2];
      if (w && i == 3'd1) begin
        m_pm = bwd[11:0]; m_po = bwd[15:12]; m_pc = '0; m_oc = '0;
      end else begin
        if (sr) m_pc = ct ? 12'd0 : m_pc + 12'd1;
        if (run && m_ctrl[10] && t_osc) m_oc = (m_oc == m_po) ? 4'd0 : m_oc + 4'd1;
      end
      if (ct) m_cnt = nx;
      if (hit) m_flag = 1'b1;
      else if (w && i == 3'd3 && bwd[0]) m_flag = 1'b0;
      if (w && i == 3'd0) m_ctrl = bwd[10:0] & 11'h7C9;
      if (w && i == 3'd2) m_cmp = bwd[CW-1:0];
      if (w && i == 3'd4) m_ier = bwd[0];
    end
  end

  function automatic logic [31:0] mread(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {21'd0, m_ctrl};
      3'd1: return {16'd0, m_po, m_pm};
      3'd2: return {{(32-CW){1'b0}}, m_cmp};
      3'd3: return {31'd0, m_flag};
      3'd4: return {31'd0, m_ier};
      3'd5: return {{(32-CW){1'b0}}, m_cnt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [4:0] a,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    bsel = s; bwr = w; baddr = a; bwd = d;
    #1;
    chk("R10 irq", {31'd0, irq}, {31'd0, m_flag & m_ier});
    if (s && !w) chk(tag, rdata, mread(a));
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, "wr");
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic rdx(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rd(a, tag);
    chk(tag, rdata, exp);
  endtask

  task automatic rds(input logic [4:0] a, input int n, input string tag);
    for (int k = 0; k < n; k++) rd(a, tag);
  endtask

  task automatic ticks(input logic b, input logic p, input logic o);
    t_bus = b; t_per = p; t_osc = o;
  endtask

  initial begin
    #(5.0 * 190000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rdx(A_CTRL, 0, "R1 ctrl"); rdx(A_PRE, 0, "R1 pre"); rdx(A_CMP, 0, "R1 cmp");
    rdx(A_STAT, 0, "R1 stat"); rdx(A_IER, 0, "R1 ier"); rdx(A_CNT, 0, "R1 cnt");
    // R12 register map
    wr(A_CTRL, 32'hFFFF_FFFE); rdx(A_CTRL, 32'h0000_07C8, "R12 ctrl mask");
    wr(A_PRE, 32'hFFFF_FFFF);  rdx(A_PRE, 32'h0000_FFFF, "R12 pre");
    wr(A_CMP, 32'hFFFF_FFFF);  rdx(A_CMP, 32'h0000_03FF, "R12 cmp");
    wr(A_CNT, 32'h0000_0123);  rdx(A_CNT, 32'h0, "R12 cnt write ignored");
    wr(A_PRE, 0); wr(A_CMP, 0);
    // R2 disabled holds
    ticks(1, 1, 1);
    wr(A_CTRL, 32'h40);
    repeat (10) cyc(0, 0, 0, 0, "idle");
    rdx(A_CNT, 0, "R2 hold while disabled");
    wr(A_CTRL, 32'h41);
    rds(A_CNT, 8, "R2 counts when enabled");
    // R3 source selection
    ticks(0, 1, 0); rds(A_CNT, 4, "R3 bus code with per tick");
    wr(A_CTRL, 32'h81); rds(A_CNT, 4, "R3 per code");
    ticks(1, 0, 1); rds(A_CNT, 4, "R3 per code ignores others");
    wr(A_CTRL, 32'h141); rds(A_CNT, 4, "R3 osc code");
    ticks(1, 1, 1); wr(A_CTRL, 32'hC1); rds(A_CNT, 6, "R3 unused code");
    // R4 main prescaler
    wr(A_CTRL, 32'h41); wr(A_PRE, 3); rds(A_CNT, 14, "R4 divide by 4");
    // R6 restart mid phase
    wr(A_PRE, 3); rds(A_CNT, 6, "R6 restart");
    wr(A_PRE, 2); rds(A_CNT, 2, "R6 restart");
    wr(A_PRE, 2); rds(A_CNT, 5, "R6 restart");
    // R5 oscillator pre-divider
    wr(A_PRE, 32'h2000); wr(A_CTRL, 32'h541); rds(A_CNT, 10, "R5 osc div 3");
    wr(A_CTRL, 32'h141); rds(A_CNT, 5, "R5 osc undivided");
    wr(A_PRE, 32'h1001); wr(A_CTRL, 32'h541); ticks(0, 0, 1); rds(A_CNT, 12, "R5 osc and main");
    // R11 wait mode
    wr(A_PRE, 0); wr(A_CTRL, 32'h41); ticks(1, 0, 0);
    wreq = 1'b1; rds(A_CNT, 5, "R11 wait stops");
    wr(A_CTRL, 32'h49); rds(A_CNT, 5, "R11 wait ignored");
    wreq = 1'b0;
    // R7 R8 match, no reload, wrap
    wr(A_CTRL, 32'h40); wr(A_STAT, 1);
    wr(A_CMP, 32'(m_cnt + 3)); wr(A_CTRL, 32'h241);
    rds(A_STAT, 5, "R8 flag on match");
    rds(A_CNT, 4, "R7 keeps counting past match");
    wr(A_STAT, 1);
    rds(A_CNT, 1030, "R7 wrap");
    rd(A_STAT, "R8 flag after wrap");
    // R8 equal compare waits for wrap
    wr(A_CTRL, 32'h40); wr(A_STAT, 1); wr(A_CMP, 32'(m_cnt));
    wr(A_CTRL, 32'h41);
    rds(A_STAT, 1021, "R8 equal does not fire");
    rds(A_STAT, 6, "R8 fires after wrap");
    // R9 write 0 keeps, write 1 clears, set beats clear
    wr(A_STAT, 0); rdx(A_STAT, 1, "R9 write 0 keeps");
    wr(A_STAT, 1); rd(A_STAT, "R9 write 1 clears");
    wr(A_CTRL, 32'h40); wr(A_CMP, 32'(m_cnt + 4)); wr(A_CTRL, 32'h41);
    repeat (6) wr(A_STAT, 1);
    wr(A_CTRL, 32'h40);
    rd(A_STAT, "R9 set wins");
    // R10 interrupt gating
    wr(A_STAT, 1); wr(A_CMP, 32'(m_cnt + 2)); wr(A_CTRL, 32'h41);
    rds(A_STAT, 4, "R10 flag masked");
    wr(A_IER, 1); rd(A_STAT, "R10 irq on");
    chk("R10 irq high", {31'd0, irq}, 32'd1);
    wr(A_STAT, 1); rd(A_STAT, "R10 cleared");
    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [4:0] a;
      logic [31:0] d;
      ticks($urandom % 3 != 0, $urandom % 2 == 0, $urandom % 4 != 0);
      wreq = ($urandom % 5) == 0;
      r = $urandom % 100;
      a = 5'((($urandom % 6)) << 2);
      if (r < 7) begin
        case (a[4:2])
          3'd0: begin
            d = $urandom & 32'h0000_FFFF;
            case ($urandom % 4)
              0: d[8:6] = 3'd1;
              1: d[8:6] = 3'd2;
              2: d[8:6] = 3'd5;
              default: ;
            endcase
            if ($urandom % 8 != 0) d[0] = 1'b1;
          end
          3'd1: d = (($urandom % 4) << 12) | ($urandom % 4);
          3'd2: d = ($urandom % 4 == 0) ? 32'(m_cnt + 2) : $urandom;
          default: d = $urandom;
        endcase
        wr(a, d);
      end else begin
        rd(a, "R7 R8 random readback");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule